// File: doc/BRIEF.md
# LCD Panel AC-Drive Modulation and Frame-Freeze Controller

This block produces two slow control signals for a display controller. The first is the AC-drive modulation level for a passive LCD panel. It is a square wave whose toggle rate comes from a 6-bit rate setting. A rate of zero makes the level flip once per frame-start strobe. A non-zero rate N makes it flip after every N line strobes.

The second signal is a one-frame freeze flag for the frame-rate-modulation (dithering) logic. When electroluminescent-panel mode is on, a long-period frame counter raises this flag for one whole frame in every `FREEZE_FRAMES` frames. During that frame the dithering logic holds its state, so two back-to-back frames show identical data. The modulation output is active only when the pin that could carry it is configured for modulation. Otherwise it is held low.

A small write port sets two registers. The control register is at address 0. The rate register is at address 1. Frame and line strobes are single-cycle pulses in the core clock domain.

Top module: `lcd_mod_ctrl`

## Requirements
- R1: After reset, `mod_out` and `freeze_out` are 0, the modulation enable and panel-mode enable are 0, and the rate is 0.
- R2: A write to address 0 sets the modulation enable from data bit 0 and the panel-mode enable from data bit 1, and ignores the other bits. A write to address 1 sets the rate from data bits 5:0 and ignores bits 7:6.
- R3: While the modulation enable is 0, `mod_out` is 0 and strobes have no effect. After the enable is set again, the level starts at 0 and counting starts from zero.
- R4: With rate 0 and modulation enabled, `mod_out` inverts in the cycle after each frame strobe, and line strobes have no effect.
- R5: With rate N (1 to 63), `mod_out` inverts in the cycle after the N-th line strobe counted since the previous inversion, and frame strobes have no effect.
- R6: A write to the rate register clears the line count, so the next inversion needs a full N line strobes counted after the write.
- R7: With panel mode enabled, `freeze_out` rises in the cycle after the `FREEZE_FRAMES`-th frame strobe counted since enabling. It falls in the cycle after the following frame strobe. The count then restarts, so the next freeze follows `FREEZE_FRAMES` strobes later.
- R8: While panel mode is disabled, `freeze_out` is 0. A write that clears the panel-mode bit drops `freeze_out` at that write's clock edge and clears the frame count.
- R9: `freeze_out` changes only at a frame strobe or a control write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| frame_stb | input | 1 | One-cycle frame-start strobe |
| line_stb | input | 1 | One-cycle line strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 1 | Register select: 0 control, 1 rate |
| wr_data | input | 8 | Register write data |
| mod_out | output | 1 | AC-drive modulation level |
| freeze_out | output | 1 | Hold frame-rate modulation for this frame |

## Verification
The bench builds the block with `FREEZE_FRAMES` set to 4 instead of the default 262143. This brings two full freeze periods, and a restart after the mode is cleared, within a few dozen frame strobes. The rate runs at its full 6-bit width, so the boundary rates 1 and 63 are driven directly. The rate-reset and disable cases are placed mid-count, so any missed counter clear shows up as an early inversion.

// File: rtl/lcd_mod_pkg.sv
package lcd_mod_pkg;
  localparam int RATE_W = 6;
  localparam int DATA_W = 8;

  localparam logic ADDR_CTL  = 1'b0;
  localparam logic ADDR_RATE = 1'b1;

  localparam int CTL_MOD_BIT = 0;
  localparam int CTL_EL_BIT  = 1;

  typedef struct packed {
    logic              mod_en;
    logic              el_en;
    logic [RATE_W-1:0] rate;
  } ctl_t;
endpackage

// File: rtl/lcd_mod_regs.sv
module lcd_mod_regs
  import lcd_mod_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctl_t              ctl,
  output logic              rate_wr,
  output logic              el_clr
);
  ctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d   = ctl_q;
    rate_wr = 1'b0;
    el_clr  = 1'b0;
    if (wr_en) begin
      if (wr_addr == ADDR_CTL) begin
        ctl_d.mod_en = wr_data[CTL_MOD_BIT];
        ctl_d.el_en  = wr_data[CTL_EL_BIT];
        el_clr       = ~wr_data[CTL_EL_BIT];
      end else begin
        ctl_d.rate = wr_data[RATE_W-1:0];
        rate_wr    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctl_q <= '0;
    else if (wr_en) ctl_q <= ctl_d;
  end

  assign ctl = ctl_q;
endmodule

// File: rtl/lcd_mod_toggle.sv
module lcd_mod_toggle #(
  parameter int RATE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [RATE_W-1:0] rate,
  input  logic              rate_wr,
  input  logic              frame_stb,
  input  logic              line_stb,
  output logic              mod_out,
  output logic [RATE_W-1:0] line_cnt
);
  logic [RATE_W-1:0] cnt_q, cnt_d;
  logic              mod_q, mod_d;
  logic              upd;

  always_comb begin
    cnt_d = cnt_q;
    mod_d = mod_q;
    if (!enable) begin
      cnt_d = '0;
      mod_d = 1'b0;
    end else if (rate_wr) begin
      cnt_d = '0;
    end else if (rate == '0) begin
      cnt_d = '0;
      if (frame_stb) mod_d = ~mod_q;
    end else if (line_stb) begin
      if (cnt_q == rate - RATE_W'(1)) begin
        cnt_d = '0;
        mod_d = ~mod_q;
      end else begin
        cnt_d = cnt_q + RATE_W'(1);
      end
    end
  end

  assign upd = (cnt_d != cnt_q) || (mod_d != mod_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mod_q <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      mod_q <= mod_d;
    end
  end

  assign mod_out  = mod_q & enable;
  assign line_cnt = cnt_q;
endmodule

// File: rtl/lcd_freeze_ctr.sv
module lcd_freeze_ctr #(
  parameter int PERIOD = 262143
) (
  input  logic clk,
  input  logic rst_n,
  input  logic el_en,
  input  logic el_clr,
  input  logic frame_stb,
  output logic freeze
);
  localparam int CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             frz_q, frz_d;
  logic             upd;

  always_comb begin
    cnt_d = cnt_q;
    frz_d = frz_q;
    if (!el_en || el_clr) begin
      cnt_d = '0;
      frz_d = 1'b0;
    end else if (frame_stb) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        frz_d = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
        frz_d = 1'b0;
      end
    end
  end

  assign upd = (cnt_d != cnt_q) || (frz_d != frz_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      frz_q <= 1'b0;
    end else if (upd) begin
      cnt_q <= cnt_d;
      frz_q <= frz_d;
    end
  end

  assign freeze = frz_q;
endmodule

// File: rtl/lcd_mod_ctrl.sv
module lcd_mod_ctrl
  import lcd_mod_pkg::*;
#(
  parameter int FREEZE_FRAMES = 262143
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_stb,
  input  logic              line_stb,
  input  logic              wr_en,
  input  logic              wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              mod_out,
  output logic              freeze_out
);
  ctl_t              ctl;
  logic              rate_wr;
  logic              el_clr;
  logic              mod_en_w;
  logic              el_en_w;
  logic [RATE_W-1:0] rate_w;
  logic [RATE_W-1:0] line_cnt_w;

  lcd_mod_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctl     (ctl),
    .rate_wr (rate_wr),
    .el_clr  (el_clr)
  );

  assign mod_en_w = ctl.mod_en;
  assign el_en_w  = ctl.el_en;
  assign rate_w   = ctl.rate;

  lcd_mod_toggle #(.RATE_W(RATE_W)) u_toggle (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (mod_en_w),
    .rate      (rate_w),
    .rate_wr   (rate_wr),
    .frame_stb (frame_stb),
    .line_stb  (line_stb),
    .mod_out   (mod_out),
    .line_cnt  (line_cnt_w)
  );

  lcd_freeze_ctr #(.PERIOD(FREEZE_FRAMES)) u_freeze (
    .clk       (clk),
    .rst_n     (rst_n),
    .el_en     (el_en_w),
    .el_clr    (el_clr),
    .frame_stb (frame_stb),
    .freeze    (freeze_out)
  );
endmodule

// File: rtl/lcd_mod_ctrl_chk.sv
module lcd_mod_ctrl_chk #(
  parameter int RATE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              frame_stb,
  input logic              line_stb,
  input logic              mod_en,
  input logic              el_en,
  input logic [RATE_W-1:0] rate,
  input logic [RATE_W-1:0] line_cnt,
  input logic              mod_out,
  input logic              freeze_out
);
  assert_mod_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |-> !mod_out);

  assert_frame_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && rate == '0 && frame_stb && !wr_en) |=> (mod_out != $past(mod_out)));

  assert_line_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && rate != '0 && !line_stb && !wr_en) |=> $stable(mod_out));

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rate != '0) |-> (line_cnt < rate));

  assert_freeze_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !el_en |-> !freeze_out);

  assert_freeze_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_stb && !wr_en) |=> $stable(freeze_out));
endmodule

bind lcd_mod_ctrl lcd_mod_ctrl_chk #(.RATE_W(lcd_mod_pkg::RATE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .frame_stb  (frame_stb),
  .line_stb   (line_stb),
  .mod_en     (mod_en_w),
  .el_en      (el_en_w),
  .rate       (rate_w),
  .line_cnt   (line_cnt_w),
  .mod_out    (mod_out),
  .freeze_out (freeze_out)
);

// File: tb/lcd_mod_ctrl_test.sv
module lcd_mod_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int FRZ = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_stb = 1'b0;
  logic       line_stb = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       mod_out;
  logic       freeze_out;

  int checks = 0;
  int errors = 0;
  logic mexp;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_mod_ctrl #(.FREEZE_FRAMES(FRZ)) uut (
    .clk(clk), .rst_n(rst_n), .frame_stb(frame_stb), .line_stb(line_stb),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mod_out(mod_out), .freeze_out(freeze_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic frame_p();
    frame_stb = 1'b1; @(negedge clk); frame_stb = 1'b0;
  endtask

  task automatic line_p();
    line_stb = 1'b1; @(negedge clk); line_stb = 1'b0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 mod after reset", mod_out, 1'b0);
    chk("R1 freeze after reset", freeze_out, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    frame_p(); line_p(); frame_p();
    chk("R3 mod held low while disabled", mod_out, 1'b0);
    chk("R8 freeze low while mode off", freeze_out, 1'b0);
  endtask

  task automatic t_rate_zero();
    wr(1'b0, 8'h01);
    wr(1'b1, 8'h00);
    chk("R2 mod starts low after enable", mod_out, 1'b0);
    frame_p();
    chk("R4 toggle on frame", mod_out, 1'b1);
    repeat (3) line_p();
    chk("R4 lines ignored at rate 0", mod_out, 1'b1);
    frame_p();
    chk("R4 second frame toggle", mod_out, 1'b0);
  endtask

  task automatic t_rate_n();
    wr(1'b1, 8'h03);
    line_p(); line_p();
    chk("R5 no toggle before third line", mod_out, 1'b0);
    frame_p();
    chk("R5 frame ignored at rate 3", mod_out, 1'b0);
    line_p();
    chk("R5 toggle on third line", mod_out, 1'b1);
    repeat (3) line_p();
    chk("R5 next interval", mod_out, 1'b0);
  endtask

  task automatic t_rate_reset();
    line_p(); line_p();
    wr(1'b1, 8'h03);
    line_p(); line_p();
    chk("R6 count cleared by rate write", mod_out, 1'b0);
    line_p();
    chk("R6 toggle after full interval", mod_out, 1'b1);
  endtask

  task automatic t_rate_max();
    wr(1'b1, 8'h3F);
    repeat (62) line_p();
    chk("R5 rate 63 holds for 62 lines", mod_out, 1'b1);
    line_p();
    chk("R5 rate 63 toggles on 63rd", mod_out, 1'b0);
  endtask

  task automatic t_upper_bits();
    wr(1'b1, 8'hC1);
    line_p();
    chk("R2 rate upper bits ignored, rate 1", mod_out, 1'b1);
    line_p();
    chk("R2 rate 1 toggles every line", mod_out, 1'b0);
    wr(1'b0, 8'hFD);
    line_p();
    chk("R2 control upper bits ignored", mod_out, 1'b1);
    chk("R2 panel mode bit clear", freeze_out, 1'b0);
  endtask

  task automatic t_mod_disable();
    wr(1'b0, 8'h00);
    chk("R3 disable forces low", mod_out, 1'b0);
    line_p(); frame_p(); line_p();
    chk("R3 strobes ignored while disabled", mod_out, 1'b0);
    wr(1'b0, 8'h01);
    chk("R3 re-enable starts low", mod_out, 1'b0);
    line_p();
    chk("R3 counting resumes", mod_out, 1'b1);
  endtask

  task automatic t_freeze();
    wr(1'b0, 8'h03);
    for (int i = 1; i < FRZ; i++) begin
      frame_p();
      chk("R7 no freeze before period", freeze_out, 1'b0);
    end
    frame_p();
    chk("R7 freeze at period", freeze_out, 1'b1);
    repeat (4) line_p();
    chk("R9 freeze held across lines", freeze_out, 1'b1);
    frame_p();
    chk("R7 freeze lasts one frame", freeze_out, 1'b0);
    for (int i = 1; i < FRZ; i++) begin
      if (i > 1) frame_p();
    end
    chk("R7 low inside second period", freeze_out, 1'b0);
    frame_p();
    chk("R7 second freeze after restart", freeze_out, 1'b1);
    wr(1'b0, 8'h01);
    chk("R8 clear drops freeze at once", freeze_out, 1'b0);
    repeat (FRZ) frame_p();
    chk("R8 no freeze while off", freeze_out, 1'b0);
    wr(1'b0, 8'h03);
    for (int i = 1; i < FRZ; i++) frame_p();
    chk("R8 count restarted from zero", freeze_out, 1'b0);
    frame_p();
    chk("R8 freeze after fresh period", freeze_out, 1'b1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mexp = 1'b0;
    @(negedge clk);
    t_reset();
    t_rate_zero();
    t_rate_n();
    t_rate_reset();
    t_rate_max();
    t_upper_bits();
    t_mod_disable();
    t_freeze();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule